// File: doc/BRIEF.md
# PLL Lock Status Flag Controller

This block keeps the two lock status bits that software reads for a clock-generation PLL. The live flag follows the lock state reported by a separate lock detector. The history flag also tells software whether the last loss of lock was expected. It is cleared whenever lock is lost. It comes back on relock only when the loss came from a deliberate change of the multiplication factor, and stays low after an unexpected loss.

Stop mode is handled as well. When the chip enters stop with the PLL switched off, the history flag value is copied into a shadow bit and both flags drop. Lock reports from the detector are ignored until stop is left. On the first relock after stop exit, the history flag takes the shadow value again.

The detector and the register bus sit outside this block. All inputs are single-cycle strobes except `pll_stop_off`, which is a level. Every flag update is registered and shows on the outputs one clock after the strobe that causes it.

Top module: `pll_lock_flags`

## Requirements
- R1: During reset and after it, both flags stay low until the first accepted lock report. One cycle after that report, both flags are high.
- R2: A `mult_chg` strobe clears both flags on the next cycle. The next accepted lock report sets both flags again.
- R3: A `det_loss` strobe while the live flag is high clears both flags on the next cycle. The next accepted lock report sets only the live flag, and the history flag stays low.
- R4: When `mult_chg` and `det_loss` arrive in the same cycle, the loss counts as intentional, so the next relock sets both flags.
- R5: A `det_loss` strobe while the live flag is already low does not change the recorded cause of the last loss.
- R6: A `stop_enter` strobe with `pll_stop_off` high clears both flags on the next cycle. Lock reports are then ignored until `stop_exit`.
- R7: On the first accepted lock report after a stop with the PLL off, the live flag goes high and the history flag takes the value it held just before stop entry. Both values 0 and 1 are checked.
- R8: A `stop_enter` strobe with `pll_stop_off` low leaves both flags unchanged.
- R9: A `mult_chg` strobe between stop exit and relock cancels the pending restore, so the relock sets the history flag to 1.
- R10: A lock report in the same cycle as `mult_chg` or `det_loss` is not accepted, and the live flag stays low.
- R11: The history flag is never high while the live flag is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| det_lock | input | 1 | Detector strobe: lock acquired |
| det_loss | input | 1 | Detector strobe: lock lost |
| mult_chg | input | 1 | Strobe: write that changes the multiplication factor |
| stop_enter | input | 1 | Strobe: stop mode entered |
| stop_exit | input | 1 | Strobe: stop mode left |
| pll_stop_off | input | 1 | Level: PLL is switched off during stop |
| lock_live_o | output | 1 | Live lock flag |
| lock_hist_o | output | 1 | History lock flag |

## Verification
A wrong cause bit or a stale shadow bit never shows while the flags are steady. It shows only at the next relock, when the history flag comes up with the wrong value one cycle after the accepted lock report. The bench therefore ends every loss scenario with a relock and checks the history flag there. A stop-tracking bit that is stuck high keeps the live flag low after a lock report. A stuck-low stop-tracking bit lets the live flag rise during stop. Both show one cycle after the lock strobe.

// File: rtl/lk_pkg.sv
package lk_pkg;

   typedef enum logic {
      LOSS_UNEXPECTED = 1'b0,
      LOSS_INTENDED   = 1'b1
   } loss_cause_e;

   typedef struct packed {
      logic acq;
      logic drop;
      logic mult_chg;
      logic halt_off;
   } flag_evt_t;

endpackage

// File: rtl/lk_cause_reg.sv
module lk_cause_reg
   import lk_pkg::*;
#(
   parameter int MFD_WINS_TIE = 1
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        mult_chg,
   input  logic        drop,
   input  logic        lock_q,
   output loss_cause_e cause_q
);

   loss_cause_e cause_d;
   logic        real_drop;

   // a loss report only counts while lock is actually held
   assign real_drop = drop & lock_q;

   generate
      if (MFD_WINS_TIE != 0) begin : g_mfd_first
         always_comb begin
            cause_d = cause_q;
            if (mult_chg)
               cause_d = LOSS_INTENDED;
            else if (real_drop)
               cause_d = LOSS_UNEXPECTED;
         end
      end else begin : g_loss_first
         always_comb begin
            cause_d = cause_q;
            if (real_drop)
               cause_d = LOSS_UNEXPECTED;
            else if (mult_chg)
               cause_d = LOSS_INTENDED;
         end
      end
   endgenerate

   // reset value lets the first lock after reset set the history flag
   always_ff @(posedge clk) begin
      if (!rst_n)
         cause_q <= LOSS_INTENDED;
      else
         cause_q <= cause_d;
   end

endmodule

// File: rtl/lk_stop_shadow.sv
module lk_stop_shadow #(
   parameter int RESTORE_ON_STOP = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic halt_off,
   input  logic stop_exit,
   input  logic mult_chg,
   input  logic relock,
   input  logic hist_q,
   output logic in_stop,
   output logic restore_pend,
   output logic shadow_q
);

   generate
      if (RESTORE_ON_STOP != 0) begin : g_restore
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               in_stop      <= 1'b0;
               restore_pend <= 1'b0;
               shadow_q     <= 1'b0;
            end else begin
               if (halt_off)
                  in_stop <= 1'b1;
               else if (stop_exit)
                  in_stop <= 1'b0;

               if (halt_off) begin
                  restore_pend <= 1'b1;
                  shadow_q     <= hist_q;
               end else if (relock || mult_chg) begin
                  restore_pend <= 1'b0;
               end
            end
         end
      end else begin : g_no_restore
         assign in_stop      = 1'b0;
         assign restore_pend = 1'b0;
         assign shadow_q     = 1'b0;
      end
   endgenerate

endmodule

// File: rtl/lk_flag_core.sv
module lk_flag_core
   import lk_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  flag_evt_t   evt,
   input  logic        in_stop,
   input  loss_cause_e cause_q,
   input  logic        restore_pend,
   input  logic        shadow_q,
   output logic        live_q,
   output logic        hist_q,
   output logic        relock
);

   logic clear_now;

   assign clear_now = evt.drop | evt.mult_chg | evt.halt_off;
   assign relock    = evt.acq & ~live_q & ~in_stop & ~clear_now;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         live_q <= 1'b0;
         hist_q <= 1'b0;
      end else if (clear_now) begin
         live_q <= 1'b0;
         hist_q <= 1'b0;
      end else if (relock) begin
         live_q <= 1'b1;
         hist_q <= restore_pend ? shadow_q : (cause_q == LOSS_INTENDED);
      end
   end

endmodule

// File: rtl/pll_lock_flags.sv
module pll_lock_flags
   import lk_pkg::*;
#(
   parameter int RESTORE_ON_STOP = 1,
   parameter int MFD_WINS_TIE    = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic det_lock,
   input  logic det_loss,
   input  logic mult_chg,
   input  logic stop_enter,
   input  logic stop_exit,
   input  logic pll_stop_off,
   output logic lock_live_o,
   output logic lock_hist_o
);

   generate
      if (RESTORE_ON_STOP < 0 || RESTORE_ON_STOP > 1) begin : g_bad_restore
         $error("RESTORE_ON_STOP must be 0 or 1");
      end
      if (MFD_WINS_TIE < 0 || MFD_WINS_TIE > 1) begin : g_bad_tie
         $error("MFD_WINS_TIE must be 0 or 1");
      end
   endgenerate

   flag_evt_t   evt;
   loss_cause_e cause_q;
   logic        in_stop;
   logic        restore_pend;
   logic        shadow_q;
   logic        relock;
   logic        live_q;
   logic        hist_q;

   always_comb begin
      evt.acq      = det_lock;
      evt.drop     = det_loss;
      evt.mult_chg = mult_chg;
      evt.halt_off = stop_enter & pll_stop_off;
   end

   lk_cause_reg #(
      .MFD_WINS_TIE (MFD_WINS_TIE)
   ) i_cause (
      .clk      (clk),
      .rst_n    (rst_n),
      .mult_chg (evt.mult_chg),
      .drop     (evt.drop),
      .lock_q   (live_q),
      .cause_q  (cause_q)
   );

   lk_stop_shadow #(
      .RESTORE_ON_STOP (RESTORE_ON_STOP)
   ) i_shadow (
      .clk          (clk),
      .rst_n        (rst_n),
      .halt_off     (evt.halt_off),
      .stop_exit    (stop_exit),
      .mult_chg     (evt.mult_chg),
      .relock       (relock),
      .hist_q       (hist_q),
      .in_stop      (in_stop),
      .restore_pend (restore_pend),
      .shadow_q     (shadow_q)
   );

   lk_flag_core i_core (
      .clk          (clk),
      .rst_n        (rst_n),
      .evt          (evt),
      .in_stop      (in_stop),
      .cause_q      (cause_q),
      .restore_pend (restore_pend),
      .shadow_q     (shadow_q),
      .live_q       (live_q),
      .hist_q       (hist_q),
      .relock       (relock)
   );

   assign lock_live_o = live_q;
   assign lock_hist_o = hist_q;

endmodule

// File: rtl/lk_flags_chk.sv
module lk_flags_chk (
   input logic clk,
   input logic rst_n,
   input logic det_lock,
   input logic det_loss,
   input logic mult_chg,
   input logic stop_enter,
   input logic pll_stop_off,
   input logic lock_live_o,
   input logic lock_hist_o,
   input logic in_stop,
   input logic relock
);

   p_relock_sets_live_r1: assert property (@(posedge clk) disable iff (!rst_n)
      relock |=> lock_live_o);

   p_mult_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
      mult_chg |=> (!lock_live_o && !lock_hist_o));

   p_loss_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
      det_loss |=> (!lock_live_o && !lock_hist_o));

   p_halt_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (stop_enter && pll_stop_off) |=> (!lock_live_o && !lock_hist_o));

   p_stop_holds_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
      in_stop |-> !lock_live_o);

   p_stop_on_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (stop_enter && !pll_stop_off && !det_lock && !det_loss && !mult_chg)
      |=> ($stable(lock_live_o) && $stable(lock_hist_o)));

   p_clear_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (det_lock && (mult_chg || det_loss)) |=> !lock_live_o);

   p_hist_needs_live_r11: assert property (@(posedge clk) disable iff (!rst_n)
      lock_hist_o |-> lock_live_o);

endmodule

bind pll_lock_flags lk_flags_chk i_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .det_lock     (det_lock),
   .det_loss     (det_loss),
   .mult_chg     (mult_chg),
   .stop_enter   (stop_enter),
   .pll_stop_off (pll_stop_off),
   .lock_live_o  (lock_live_o),
   .lock_hist_o  (lock_hist_o),
   .in_stop      (in_stop),
   .relock       (relock)
);

// File: tb/test_pll_lock_flags.sv
`timescale 1ns/1ps
module test_pll_lock_flags;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic det_lock = 1'b0;
   logic det_loss = 1'b0;
   logic mult_chg = 1'b0;
   logic stop_enter = 1'b0;
   logic stop_exit = 1'b0;
   logic pll_stop_off = 1'b0;
   logic lock_live_o;
   logic lock_hist_o;

   int n_total = 0;
   int n_bad = 0;
   int r11_viol = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   pll_lock_flags i_pll_lock_flags (
      .clk          (clk),
      .rst_n        (rst_n),
      .det_lock     (det_lock),
      .det_loss     (det_loss),
      .mult_chg     (mult_chg),
      .stop_enter   (stop_enter),
      .stop_exit    (stop_exit),
      .pll_stop_off (pll_stop_off),
      .lock_live_o  (lock_live_o),
      .lock_hist_o  (lock_hist_o)
   );

   // R11 monitor away from the active edge
   always @(negedge clk) begin
      if (rst_n && lock_hist_o && !lock_live_o)
         r11_viol++;
   end

   task automatic chk(input string req, input logic live_e, input logic hist_e);
      n_total++;
      if (lock_live_o !== live_e || lock_hist_o !== hist_e) begin
         n_bad++;
         $display("FAIL %s: live/hist actual=%b%b expected=%b%b",
                  req, lock_live_o, lock_hist_o, live_e, hist_e);
      end
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   // each strobe task drives at a falling edge; outputs are settled one edge later
   task automatic p_lock();
      det_lock = 1'b1; @(negedge clk); det_lock = 1'b0;
   endtask
   task automatic p_loss();
      det_loss = 1'b1; @(negedge clk); det_loss = 1'b0;
   endtask
   task automatic p_mult();
      mult_chg = 1'b1; @(negedge clk); mult_chg = 1'b0;
   endtask
   task automatic p_enter(input logic off);
      pll_stop_off = off; stop_enter = 1'b1; @(negedge clk); stop_enter = 1'b0;
   endtask
   task automatic p_exit();
      stop_exit = 1'b1; @(negedge clk); stop_exit = 1'b0; pll_stop_off = 1'b0;
   endtask

   task automatic t_reset();
      rst_n = 1'b0; idle(3);
      chk("R1 in reset", 1'b0, 1'b0);
      rst_n = 1'b1; idle(3);
      chk("R1 idle after reset", 1'b0, 1'b0);
      p_lock();
      chk("R1 first lock", 1'b1, 1'b1);
   endtask

   task automatic t_mult();
      p_mult();
      chk("R2 mult clears", 1'b0, 1'b0);
      idle(2);
      p_lock();
      chk("R2 relock after mult", 1'b1, 1'b1);
   endtask

   task automatic t_unexpected();
      p_loss();
      chk("R3 loss clears", 1'b0, 1'b0);
      p_lock();
      chk("R3 relock after loss", 1'b1, 1'b0);
   endtask

   task automatic t_tie();
      mult_chg = 1'b1; det_loss = 1'b1; @(negedge clk);
      mult_chg = 1'b0; det_loss = 1'b0;
      chk("R4 tie clears", 1'b0, 1'b0);
      p_lock();
      chk("R4 tie is intentional", 1'b1, 1'b1);
   endtask

   task automatic t_loss_unlocked();
      p_mult();
      p_loss();
      chk("R5 loss while unlocked", 1'b0, 1'b0);
      p_lock();
      chk("R5 cause kept", 1'b1, 1'b1);
   endtask

   task automatic t_stop_restore1();
      p_enter(1'b1);
      chk("R6 stop off clears", 1'b0, 1'b0);
      p_lock();
      chk("R6 lock ignored in stop", 1'b0, 1'b0);
      p_exit();
      p_lock();
      chk("R7 restore 1", 1'b1, 1'b1);
   endtask

   task automatic t_stop_restore0();
      p_loss(); p_lock();
      chk("R7 setup hist 0", 1'b1, 1'b0);
      p_enter(1'b1);
      p_exit();
      p_mult(); p_loss();
      p_lock();
      chk("R9 mult cancels restore", 1'b1, 1'b1);
      p_loss(); p_lock();
      p_enter(1'b1);
      p_exit();
      p_lock();
      chk("R7 restore 0", 1'b1, 1'b0);
   endtask

   task automatic t_stop_on();
      p_enter(1'b0);
      chk("R8 stop with pll on", 1'b1, 1'b0);
      idle(2);
      p_exit();
      chk("R8 exit with pll on", 1'b1, 1'b0);
   endtask

   task automatic t_prio();
      p_mult();
      det_lock = 1'b1; mult_chg = 1'b1; @(negedge clk);
      det_lock = 1'b0; mult_chg = 1'b0;
      chk("R10 lock with mult", 1'b0, 1'b0);
      det_lock = 1'b1; det_loss = 1'b1; @(negedge clk);
      det_lock = 1'b0; det_loss = 1'b0;
      chk("R10 lock with loss", 1'b0, 1'b0);
      p_lock();
      chk("R10 later lock accepted", 1'b1, 1'b1);
   endtask

   initial begin
      @(negedge clk);
      t_reset();
      t_mult();
      t_unexpected();
      t_tie();
      t_loss_unlocked();
      t_stop_restore1();
      t_stop_restore0();
      t_stop_on();
      t_prio();
      n_total++;
      if (r11_viol != 0) begin
         n_bad++;
         $display("FAIL R11: violations actual=%0d expected=0", r11_viol);
      end
      if (!done) begin
         done = 1'b1;
         $display("test done: total=%0d bad=%0d", n_total, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_total++;
         n_bad++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("test done: total=%0d bad=%0d", n_total, n_bad);
         $finish;
      end
   end

endmodule